// File: doc/BRIEF.md
# MDIO Management Master with Register Access

This block lets a host run Clause 22 management frames on an MDIO bus through three word registers. The host packs a PHY address, a register address, an operation and, for writes, sixteen data bits into one command word. Writing it starts a complete frame. The host polls a busy flag in the status word. After a read it collects the returned value and two error flags from the data word.

The block produces MDC by dividing the system clock, and only while a frame is running. MDIO is handled as an open-drain pin through separate output, output-enable and input signals. A frame runs through five named states:

- **ST_IDLE**: no frame is running.
- **ST_PRE**: the preamble.
- **ST_HDR**: start, opcode and the two addresses.
- **ST_TA**: the turnaround.
- **ST_DATA**: the sixteen data bits.

State changes happen only on MDC falling edges:

| Transition | Condition |
|---|---|
| ST_IDLE to ST_PRE | A command is accepted. |
| ST_PRE to ST_HDR | After 32 bits. |
| ST_HDR to ST_TA | After 14 bits. |
| ST_TA to ST_DATA | After 2 bits. |
| ST_DATA to ST_IDLE | After 16 bits, which also completes the frame. |

Top module: `mdio_host_master`

## Requirements
- R1: After reset, the status word and the data word read 0, MDC is low and MDIO output-enable is low.
- R2: The status word is at word index 0 (byte 0x0). Its bit 3 reads 1 from the cycle after a command is accepted until the frame has finished, and reads 0 otherwise.
- R3: The command word is at word index 2 (byte 0x8). A write there starts a frame only when bit 31 is 1. Without bit 31, no frame runs and the data word keeps its value.
- R4: The command word carries the PHY address in bits 29:25, the register address in bits 24:20 and the write data in bits 19:4. Bit 1 requests a write and bit 2 requests a read.
- R5: A write frame is 64 MDC cycles long and sends, MSB first: 32 ones, 01, opcode 01, PHY address, register address, 10, then the 16 data bits. Afterwards the data word reads 0.
- R6: A read frame sends 32 ones, 01, opcode 10 and the two addresses. It then releases MDIO for the turnaround and the data. The 16 bits sampled from the PHY appear in data word bits 15:0, with bits 17:16 at 0 when the PHY answered.
- R7: If the PHY does not drive the second turnaround bit low during a read, data word bit 16 is set.
- R8: A command with bit 31 set that has both operation bits set, or neither, starts no frame. The data word then reads exactly bit 17 set.
- R9: A command written while busy is 1 is ignored, and the running frame completes unchanged.
- R10: MDC has a period of 2*HALF_DIV system clocks during a frame and stays low otherwise. MDIO changes only when MDC falls, so it is stable at every MDC rising edge.
- R11: The data word is at word index 3 (byte 0xC). Reads return data one cycle after the read strobe. MDIO output-enable is low whenever no frame is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Word index (byte offset / 4) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line as seen at the pin |

## Verification
Write frames are swept over all 32 PHY addresses, each paired with a different register address and a computed data pattern, which separates the field positions from one another. Read frames are swept over all 32 register addresses, with PHY addresses and returned data derived arithmetically. This exercises capture order and turnaround release. A silent PHY tells an acknowledged read apart from a missing turnaround answer. Commands with both or neither operation bit, commands without the valid bit, and commands sent while busy tell rejection and ignoring apart from a real start, and the recorded line bits show which frame actually ran.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TA,
        ST_DATA
    } frame_state_t;

    localparam logic [1:0] WORD_STATUS = 2'd0;
    localparam logic [1:0] WORD_CMD    = 2'd2;
    localparam logic [1:0] WORD_DATA   = 2'd3;

    localparam int CMD_VALID_BIT = 31;
    localparam int CMD_WR_BIT    = 1;
    localparam int CMD_RD_BIT    = 2;
    localparam int CMD_PHY_LSB   = 25;
    localparam int CMD_REG_LSB   = 20;
    localparam int CMD_WDAT_LSB  = 4;
    localparam int STAT_BUSY_BIT = 3;
    localparam int ERR_TA_BIT    = 16;
    localparam int ERR_REJ_BIT   = 17;

    localparam int PRE_BITS  = 32;
    localparam int HDR_BITS  = 14;
    localparam int TA_BITS   = 2;
    localparam int DATA_BITS = 16;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CNT_W-1:0] div_q;
    logic             mdc_q;
    logic             wrap;

    assign wrap      = run && (div_q == CNT_W'(HALF_DIV - 1));
    assign rise_tick = wrap && !mdc_q;
    assign fall_tick = wrap && mdc_q;
    assign mdc       = mdc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            mdc_q <= 1'b0;
        end else if (!run) begin
            div_q <= '0;
            mdc_q <= 1'b0;
        end else if (wrap) begin
            div_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        is_read,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wr_value,
    input  logic        rise_tick,
    input  logic        fall_tick,
    input  logic        mdio_i,
    output logic        busy,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] rd_value,
    output logic        ta_err,
    output logic        done
);
    frame_state_t state_q, state_d;
    logic [4:0]   cnt_q, cnt_d;
    logic [31:0]  shift_q;
    logic         read_q;
    logic [15:0]  rd_q;
    logic         ta_err_q;
    logic         done_q;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: if (start) begin
                state_d = ST_PRE;
                cnt_d   = 5'(PRE_BITS - 1);
            end
            ST_PRE: if (fall_tick) begin
                if (cnt_q == 5'd0) begin
                    state_d = ST_HDR;
                    cnt_d   = 5'(HDR_BITS - 1);
                end else cnt_d = cnt_q - 1'b1;
            end
            ST_HDR: if (fall_tick) begin
                if (cnt_q == 5'd0) begin
                    state_d = ST_TA;
                    cnt_d   = 5'(TA_BITS - 1);
                end else cnt_d = cnt_q - 1'b1;
            end
            ST_TA: if (fall_tick) begin
                if (cnt_q == 5'd0) begin
                    state_d = ST_DATA;
                    cnt_d   = 5'(DATA_BITS - 1);
                end else cnt_d = cnt_q - 1'b1;
            end
            ST_DATA: if (fall_tick) begin
                if (cnt_q == 5'd0) state_d = ST_IDLE;
                else cnt_d = cnt_q - 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            shift_q  <= '0;
            read_q   <= 1'b0;
            rd_q     <= '0;
            ta_err_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            done_q  <= (state_q == ST_DATA) && fall_tick && (cnt_q == 5'd0);
            if (state_q == ST_IDLE && start) begin
                shift_q  <= {2'b01, (is_read ? 2'b10 : 2'b01), phy_addr, reg_addr,
                             2'b10, wr_value};
                read_q   <= is_read;
                rd_q     <= '0;
                ta_err_q <= 1'b0;
            end else begin
                if (fall_tick && (state_q == ST_HDR || state_q == ST_TA ||
                                  state_q == ST_DATA))
                    shift_q <= {shift_q[30:0], 1'b0};
                if (rise_tick && read_q && state_q == ST_TA && cnt_q == 5'd0)
                    ta_err_q <= mdio_i;
                if (rise_tick && read_q && state_q == ST_DATA)
                    rd_q <= {rd_q[14:0], mdio_i};
            end
        end
    end

    always_comb begin
        busy    = (state_q != ST_IDLE);
        mdio_o  = 1'b0;
        mdio_oe = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PRE: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b1;
            end
            ST_HDR: begin
                mdio_o  = shift_q[31];
                mdio_oe = 1'b1;
            end
            ST_TA, ST_DATA: begin
                mdio_o  = shift_q[31];
                mdio_oe = !read_q;
            end
            default: ;
        endcase
    end

    assign rd_value = rd_q;
    assign ta_err   = ta_err_q;
    assign done     = done_q;
endmodule

// File: rtl/mdio_host_master.sv
module mdio_host_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic        frame_busy;
    logic        rise_tick, fall_tick;
    logic        cmd_hit, op_ok, start;
    logic [15:0] rd_value;
    logic        ta_err, done;
    logic [31:0] data_q;
    logic [31:0] rdata_q;

    assign cmd_hit = bus_wr && (bus_addr == WORD_CMD) && bus_wdata[CMD_VALID_BIT]
                     && !frame_busy;
    assign op_ok   = bus_wdata[CMD_WR_BIT] ^ bus_wdata[CMD_RD_BIT];
    assign start   = cmd_hit && op_ok;

    mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) i_mdc_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (frame_busy),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_engine i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .is_read   (bus_wdata[CMD_RD_BIT]),
        .phy_addr  (bus_wdata[CMD_PHY_LSB +: 5]),
        .reg_addr  (bus_wdata[CMD_REG_LSB +: 5]),
        .wr_value  (bus_wdata[CMD_WDAT_LSB +: 16]),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .busy      (frame_busy),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rd_value  (rd_value),
        .ta_err    (ta_err),
        .done      (done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            rdata_q <= '0;
        end else begin
            if (start)
                data_q <= '0;
            else if (cmd_hit)
                data_q <= 32'(1) << ERR_REJ_BIT;
            else if (done)
                data_q <= {14'd0, 1'b0, ta_err, rd_value};
            if (bus_rd) begin
                unique case (bus_addr)
                    WORD_STATUS: rdata_q <= 32'(frame_busy) << STAT_BUSY_BIT;
                    WORD_DATA:   rdata_q <= data_q;
                    default:     rdata_q <= '0;
                endcase
            end
        end
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/mdio_master_checker.sv
module mdio_master_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        bus_wr,
    input logic [1:0]  bus_addr,
    input logic [31:0] bus_wdata
);
    logic cmd_wr;
    assign cmd_wr = bus_wr && (bus_addr == 2'd2);

    AST_IDLE_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe); // R11
    AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc); // R10
    AST_MDIO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(rst_n)) |-> $stable(mdio_o)); // R10
    AST_REJECT_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_wr && bus_wdata[31] && (bus_wdata[1] == bus_wdata[2])) |=> !busy); // R8
    AST_NOVALID_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_wr && !bus_wdata[31]) |=> !busy); // R3
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_wr && bus_wdata[31] && (bus_wdata[1] != bus_wdata[2])) |=> busy); // R2
endmodule

bind mdio_host_master mdio_master_checker i_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (frame_busy),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
);

// File: tb/test_mdio_host_master.sv
`timescale 1ns/1ps
module test_mdio_host_master;
    localparam int HALF_DIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int errors = 0, checks = 0;
    logic        phy_ack = 1'b0, phy_is_read = 1'b0;
    logic [15:0] phy_data = '0;
    logic        phy_en = 1'b0, phy_val = 1'b1;
    int          rise_cnt = 0;
    logic [63:0] seen = '0;
    realtime     t_rise0 = 0, t_rise1 = 0;

    always #4 clk = ~clk;

    mdio_host_master #(.HALF_DIV(HALF_DIV)) i_mdio_host_master (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);

    always @(posedge mdc) begin
        if (rise_cnt < 64) seen[63 - rise_cnt] = mdio_i;
        if (rise_cnt == 0) t_rise0 = $realtime;
        if (rise_cnt == 1) t_rise1 = $realtime;
        rise_cnt = rise_cnt + 1;
    end

    always @(negedge mdc) begin
        if (phy_ack && phy_is_read && rise_cnt == 47) begin
            phy_en = 1'b1; phy_val = 1'b0;
        end else if (phy_ack && phy_is_read && rise_cnt >= 48 && rise_cnt <= 63) begin
            phy_en = 1'b1; phy_val = phy_data[63 - rise_cnt];
        end else begin
            phy_en = 1'b0;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 4000; i++) begin
            bus_read(2'd0, s);
            if (!s[3]) break;
        end
    endtask

    function automatic logic [31:0] cmd(input logic rd, input logic [4:0] p,
                                        input logic [4:0] r, input logic [15:0] d);
        return {1'b1, 1'b0, p, r, d, 1'b0, rd, !rd, 1'b0};
    endfunction

    function automatic logic [63:0] frame(input logic rd, input logic [4:0] p,
                                          input logic [4:0] r, input logic [1:0] ta,
                                          input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r, ta, d};
    endfunction

    task automatic run_frame(input logic rd, input logic ack, input logic [4:0] p,
                             input logic [4:0] r, input logic [15:0] d,
                             input logic [63:0] exp_line, input logic [31:0] exp_data);
        logic [31:0] s;
        rise_cnt = 0; seen = '0; phy_is_read = rd; phy_ack = ack; phy_data = d;
        bus_write(2'd2, cmd(rd, p, r, rd ? 16'h0 : d));
        bus_read(2'd0, s);
        check("R2 busy during frame", 64'(s), 64'h8);
        wait_idle();
        check("R5/R6 MDC cycles per frame", 64'(rise_cnt), 64'd64);
        check(rd ? "R6 read line bits" : "R5 write line bits (R4 fields)", seen, exp_line);
        bus_read(2'd3, s);
        check(rd ? "R6/R7 data word" : "R5 data word after write", 64'(s), 64'(exp_data));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] s;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 mdc low", 64'(mdc), 64'd0);
        check("R1 oe low", 64'(mdio_oe), 64'd0);
        rst_n = 1'b1;
        bus_read(2'd0, s); check("R1 status", 64'(s), 64'd0);
        bus_read(2'd3, s); check("R1 data", 64'(s), 64'd0);

        // R4 R5 write sweep over all PHY addresses
        for (int p = 0; p < 32; p++) begin
            logic [15:0] d;
            d = 16'(p * 16'h0841) ^ 16'hA5C3;
            run_frame(1'b0, 1'b0, 5'(p), 5'(31 - p), d,
                      frame(1'b0, 5'(p), 5'(31 - p), 2'b10, d), 32'h0);
        end
        // R10 MDC period
        check("R10 MDC period ns", 64'(int'(t_rise1 - t_rise0)), 64'(2 * HALF_DIV * 8));

        // R6 read sweep over all register addresses
        for (int r = 0; r < 32; r++) begin
            logic [15:0] d;
            logic [4:0]  p;
            d = 16'((r + 1) * 4661);
            p = 5'((r * 7) % 32);
            run_frame(1'b1, 1'b1, p, 5'(r), d,
                      frame(1'b1, p, 5'(r), 2'b10, d), {16'h0, d});
        end

        // R7 silent PHY: turnaround not driven low
        run_frame(1'b1, 1'b0, 5'd9, 5'd4, 16'h0,
                  frame(1'b1, 5'd9, 5'd4, 2'b11, 16'hFFFF), 32'h0001_FFFF);

        // R8 both / neither operation bit
        rise_cnt = 0;
        bus_write(2'd2, 32'h8000_0006);
        bus_read(2'd0, s); check("R8 both ops no busy", 64'(s), 64'd0);
        bus_read(2'd3, s); check("R8 both ops data word", 64'(s), 64'h2_0000);
        run_frame(1'b1, 1'b1, 5'd1, 5'd2, 16'h5A5A,
                  frame(1'b1, 5'd1, 5'd2, 2'b10, 16'h5A5A), 32'h5A5A);
        rise_cnt = 0;
        bus_write(2'd2, 32'h8000_0000);
        bus_read(2'd0, s); check("R8 neither op no busy", 64'(s), 64'd0);
        bus_read(2'd3, s); check("R8 neither op data word", 64'(s), 64'h2_0000);
        repeat (40) @(negedge clk);
        check("R8 no MDC edges", 64'(rise_cnt), 64'd0);

        // R3 command without valid bit
        run_frame(1'b1, 1'b1, 5'd3, 5'd6, 16'hC3C3,
                  frame(1'b1, 5'd3, 5'd6, 2'b10, 16'hC3C3), 32'hC3C3);
        rise_cnt = 0;
        bus_write(2'd2, cmd(1'b0, 5'd7, 5'd7, 16'h1111) & 32'h7FFF_FFFF);
        bus_read(2'd0, s); check("R3 no valid no busy", 64'(s), 64'd0);
        repeat (40) @(negedge clk);
        check("R3 no valid no MDC", 64'(rise_cnt), 64'd0);
        bus_read(2'd3, s); check("R3 data word kept", 64'(s), 64'hC3C3);

        // R9 command while busy ignored
        rise_cnt = 0; seen = '0; phy_is_read = 1'b0; phy_ack = 1'b0;
        bus_write(2'd2, cmd(1'b0, 5'd21, 5'd10, 16'hBEEF));
        bus_write(2'd2, cmd(1'b1, 5'd2, 5'd3, 16'h0));
        bus_write(2'd2, 32'h8000_0006);
        wait_idle();
        check("R9 MDC cycles", 64'(rise_cnt), 64'd64);
        check("R9 first frame unchanged", seen, frame(1'b0, 5'd21, 5'd10, 2'b10, 16'hBEEF));
        bus_read(2'd3, s); check("R9 data word", 64'(s), 64'd0);

        // R11 idle outputs and unused word index
        check("R11 oe idle", 64'(mdio_oe), 64'd0);
        bus_read(2'd1, s); check("R11 unmapped word", 64'(s), 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule